// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received frame is kept, using only its 48-bit destination address. Frame parsing happens elsewhere. The parser presents the address together with a one-cycle strobe. Two cycles later the filter returns an accept or drop verdict. The verdict also gives the reason: an exact-entry hit with its index, a multicast hash hit, broadcast, or promiscuous mode.

The filter holds a bank of exact-match entries, a 64-bin multicast hash bitmap and a small mode word. Software loads all of them through a simple register-write port. A programmable count splits the exact entries into two groups. The entries below the count match only unicast addresses. The entries at or above it match only multicast addresses. Multicast addresses that do not fit in the bank go through the hash table. The hash index is the 48 address bits XOR-folded into 6 bits. Setting every bin to 1 accepts all multicast traffic.

Top module: `rx_daddr_filter`

## Requirements
- R1: Address byte n of the destination is carried on `da[8n+7:8n]`. An exact entry is written as a low word at config address i, holding bytes 3..0 with byte 0 in bits 7:0. Its high word is written at config address 8+i and holds bytes 5..4 with byte 4 in bits 7:0. An entry matches only when all 48 bits are equal.
- R2: Each entry has a valid flag. A low-word write clears it and a high-word write sets it. An invalid entry, including one never written since reset, never matches, even an all-zero address.
- R3: The mode word is written at config address 18. The unicast count is in bits 6:3, and a written value above 8 is stored as 8. An address is multicast when bit 0 of byte 0 is 1. Entries with an index below the count match only unicast addresses. Entries at or above it match only multicast addresses.
- R4: When several entries match, the lowest index wins. The verdict is accept with reason 1 (exact) and `dec_index` set to that index.
- R5: The hash bin is a 6-bit value. Bin bit j is the XOR of address bits `da[j]`, `da[j+6]`, … `da[j+42]`. Bins 0–31 are written as a word at config address 16 and bins 32–63 at address 17. When mode bit 1 (hash enable) is set, a multicast, non-broadcast address with no exact hit whose bin is 1 is accepted with reason 2. Unicast addresses never use the hash.
- R6: The all-ones address with no exact hit is accepted with reason 3 when mode bit 2 (broadcast disable) is 0, and dropped when it is 1. Broadcast never uses the hash table.
- R7: When mode bit 0 (promiscuous) is set, every address is accepted with reason 4. This takes priority over every other reason.
- R8: `dec_valid` pulses for exactly one cycle, two clock edges after each `da_valid` cycle. Back-to-back strobes give back-to-back verdicts in order.
- R9: After reset, all entries are invalid, the hash bins and mode bits are 0, the unicast count is 1, and all outputs are 0.
- R10: An address with no reason to accept gets `dec_accept`=0, reason 0 (drop) and index 0. `dec_accept` is 0 whenever `dec_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 5 | Config word address |
| cfg_wdata | input | 32 | Config write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | 1 = keep frame |
| dec_reason | output | 3 | 0 drop, 1 exact, 2 hash, 3 broadcast, 4 promiscuous |
| dec_index | output | 3 | Winning exact entry index (0 unless reason 1) |

## Verification
The bench goes after the byte placement of the entry words. A filter that swapped bytes 3 and 0 would reject the station address it was given. It also re-writes an entry's low word and checks that the entry stops matching. A filter that kept the old valid flag would match a half-written entry. It moves the unicast count across entries of both kinds, including a clamped value, to catch a bank that ignores the address class. Finally, it picks addresses whose bins fall in each half of the hash bitmap, so a swapped word or a wrongly folded bit drops the wrong frame. Priority cases cover two entries holding the same address, broadcast against a full hash table, and promiscuous mode against an exact hit.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int ADDR_W = 48;
    localparam int WORD_W = 32;
    localparam int HASH_W = 6;
    localparam int BINS   = 1 << HASH_W;

    typedef enum logic [2:0] {
        RSN_DROP    = 3'd0,
        RSN_EXACT   = 3'd1,
        RSN_HASH    = 3'd2,
        RSN_BCAST   = 3'd3,
        RSN_PROMISC = 3'd4
    } reason_e;

    typedef struct packed {
        logic promisc;
        logic hash_en;
        logic bcast_dis;
    } mode_t;

    typedef struct packed {
        logic is_bc;
        logic hash_hit;
        logic promisc;
        logic bcast_dis;
    } s1_flags_t;

    // Fold address bit k into hash bit (k mod HASH_W), bytes LSB first.
    function automatic logic [HASH_W-1:0] fold_hash(input logic [ADDR_W-1:0] a);
        logic [HASH_W-1:0] h;
        h = '0;
        for (int k = 0; k < ADDR_W; k++) begin
            h[k % HASH_W] = h[k % HASH_W] ^ a[k];
        end
        return h;
    endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int N_ENTRY = 8,
    parameter int CFG_AW  = $clog2(2*N_ENTRY+3),
    parameter int NU_W    = $clog2(N_ENTRY+1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [WORD_W-1:0]                 cfg_wdata,
    output logic [N_ENTRY-1:0][ADDR_W-1:0]    ent_addr,
    output logic [N_ENTRY-1:0]                ent_vld,
    output logic [BINS-1:0]                   hash_tbl,
    output mode_t                             mode,
    output logic [NU_W-1:0]                   n_ucast
);

    localparam int HI_W       = ADDR_W - WORD_W;
    localparam int A_HASH_LO  = 2*N_ENTRY;
    localparam int A_HASH_HI  = 2*N_ENTRY + 1;
    localparam int A_MODE     = 2*N_ENTRY + 2;

    logic [NU_W-1:0] nuc_wr;
    logic            unused_wbits;

    assign unused_wbits = ^cfg_wdata[WORD_W-1:NU_W+3];
    assign nuc_wr = (cfg_wdata[NU_W+2:3] > NU_W'(N_ENTRY)) ? NU_W'(N_ENTRY)
                                                            : cfg_wdata[NU_W+2:3];

    for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_addr[i] <= '0;
                ent_vld[i]  <= 1'b0;
            end else if (cfg_we && cfg_addr == CFG_AW'(i)) begin
                ent_addr[i][WORD_W-1:0] <= cfg_wdata;
                ent_vld[i]              <= 1'b0;
            end else if (cfg_we && cfg_addr == CFG_AW'(N_ENTRY + i)) begin
                ent_addr[i][ADDR_W-1:WORD_W] <= cfg_wdata[HI_W-1:0];
                ent_vld[i]                   <= 1'b1;
            end
        end

        // R2
        lo_clr_vld_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_addr == CFG_AW'(i)) |=> !ent_vld[i]);
        // R2
        hi_set_vld_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && cfg_addr == CFG_AW'(N_ENTRY + i)) |=> ent_vld[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hash_tbl <= '0;
            mode     <= '0;
            n_ucast  <= NU_W'(1);
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(A_HASH_LO)) begin
                hash_tbl[WORD_W-1:0] <= cfg_wdata;
            end else if (cfg_addr == CFG_AW'(A_HASH_HI)) begin
                hash_tbl[BINS-1:WORD_W] <= cfg_wdata;
            end else if (cfg_addr == CFG_AW'(A_MODE)) begin
                mode.promisc   <= cfg_wdata[0];
                mode.hash_en   <= cfg_wdata[1];
                mode.bcast_dis <= cfg_wdata[2];
                n_ucast        <= nuc_wr;
            end
        end
    end

    // R3
    nuc_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == CFG_AW'(A_MODE) && cfg_wdata[NU_W+2:3] > NU_W'(N_ENTRY))
        |=> n_ucast == NU_W'(N_ENTRY));

endmodule

// File: rtl/rxf_match.sv
module rxf_match
    import rxf_pkg::*;
#(
    parameter int N_ENTRY = 8,
    parameter int NU_W    = $clog2(N_ENTRY+1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              da_valid,
    input  logic [ADDR_W-1:0]                 da,
    input  logic [N_ENTRY-1:0][ADDR_W-1:0]    ent_addr,
    input  logic [N_ENTRY-1:0]                ent_vld,
    input  logic [BINS-1:0]                   hash_tbl,
    input  mode_t                             mode,
    input  logic [NU_W-1:0]                   n_ucast,
    output logic                              s1_valid,
    output logic [N_ENTRY-1:0]                s1_hits,
    output s1_flags_t                         s1_flags
);

    logic              is_mc;
    logic              is_bc;
    logic [HASH_W-1:0] bin;
    logic [N_ENTRY-1:0] hit;
    s1_flags_t         flags_d;

    assign is_mc = da[0];
    assign is_bc = &da;
    assign bin   = fold_hash(da);

    for (genvar i = 0; i < N_ENTRY; i++) begin : g_cmp
        logic in_mc_zone;
        assign in_mc_zone = (i >= int'(n_ucast));
        assign hit[i] = ent_vld[i] && (ent_addr[i] == da) && (is_mc == in_mc_zone);
    end

    always_comb begin
        flags_d.is_bc     = is_bc;
        flags_d.hash_hit  = mode.hash_en && is_mc && !is_bc && hash_tbl[bin];
        flags_d.promisc   = mode.promisc;
        flags_d.bcast_dis = mode.bcast_dis;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_hits  <= '0;
            s1_flags <= '0;
        end else begin
            s1_valid <= da_valid;
            s1_hits  <= da_valid ? hit : '0;
            s1_flags <= da_valid ? flags_d : '0;
        end
    end

    // R8
    stage1_follow_chk: assert property (@(posedge clk) disable iff (rst)
        da_valid |=> s1_valid);

    // R5
    uc_no_hash_chk: assert property (@(posedge clk) disable iff (rst)
        (da_valid && !da[0]) |=> !s1_flags.hash_hit);

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int N_ENTRY = 8,
    parameter int IDX_W   = $clog2(N_ENTRY)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               s1_valid,
    input  logic [N_ENTRY-1:0] s1_hits,
    input  s1_flags_t          s1_flags,
    output logic               dec_valid,
    output logic               dec_accept,
    output reason_e            dec_reason,
    output logic [IDX_W-1:0]   dec_index
);

    logic             found;
    logic [IDX_W-1:0] first_idx;
    reason_e          rsn_d;
    logic [IDX_W-1:0] idx_d;

    always_comb begin
        found     = 1'b0;
        first_idx = '0;
        for (int i = 0; i < N_ENTRY; i++) begin
            if (!found && s1_hits[i]) begin
                found     = 1'b1;
                first_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        idx_d = '0;
        if (s1_flags.promisc) begin
            rsn_d = RSN_PROMISC;
        end else if (found) begin
            rsn_d = RSN_EXACT;
            idx_d = first_idx;
        end else if (s1_flags.is_bc) begin
            rsn_d = s1_flags.bcast_dis ? RSN_DROP : RSN_BCAST;
        end else if (s1_flags.hash_hit) begin
            rsn_d = RSN_HASH;
        end else begin
            rsn_d = RSN_DROP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_reason <= RSN_DROP;
            dec_index  <= '0;
        end else begin
            dec_valid  <= s1_valid;
            dec_accept <= s1_valid && (rsn_d != RSN_DROP);
            dec_reason <= s1_valid ? rsn_d : RSN_DROP;
            dec_index  <= s1_valid ? idx_d : '0;
        end
    end

    // R8
    verdict_follow_chk: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> dec_valid);
    // R7
    promisc_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_flags.promisc) |=> (dec_accept && dec_reason == RSN_PROMISC));
    // R10
    idle_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !dec_accept);
    // R10
    no_reason_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_flags.promisc && s1_hits == '0 && !s1_flags.is_bc
         && !s1_flags.hash_hit) |=> !dec_accept);

endmodule

// File: rtl/rx_daddr_filter.sv
module rx_daddr_filter
    import rxf_pkg::*;
#(
    parameter int N_ENTRY = 8,
    parameter int CFG_AW  = $clog2(2*N_ENTRY+3),
    parameter int IDX_W   = $clog2(N_ENTRY)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              da_valid,
    input  logic [47:0]       da,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [2:0]        dec_reason,
    output logic [IDX_W-1:0]  dec_index
);

    localparam int NU_W = $clog2(N_ENTRY+1);

    logic [N_ENTRY-1:0][ADDR_W-1:0] ent_addr;
    logic [N_ENTRY-1:0]             ent_vld;
    logic [BINS-1:0]                hash_tbl;
    mode_t                          mode;
    logic [NU_W-1:0]                n_ucast;
    logic                           s1_valid;
    logic [N_ENTRY-1:0]             s1_hits;
    s1_flags_t                      s1_flags;
    reason_e                        reason;

    rxf_cfg_regs #(.N_ENTRY(N_ENTRY), .CFG_AW(CFG_AW), .NU_W(NU_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .ent_addr (ent_addr),
        .ent_vld  (ent_vld),
        .hash_tbl (hash_tbl),
        .mode     (mode),
        .n_ucast  (n_ucast)
    );

    rxf_match #(.N_ENTRY(N_ENTRY), .NU_W(NU_W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .da_valid (da_valid),
        .da       (da),
        .ent_addr (ent_addr),
        .ent_vld  (ent_vld),
        .hash_tbl (hash_tbl),
        .mode     (mode),
        .n_ucast  (n_ucast),
        .s1_valid (s1_valid),
        .s1_hits  (s1_hits),
        .s1_flags (s1_flags)
    );

    rxf_decide #(.N_ENTRY(N_ENTRY), .IDX_W(IDX_W)) u_decide (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_hits   (s1_hits),
        .s1_flags  (s1_flags),
        .dec_valid (dec_valid),
        .dec_accept(dec_accept),
        .dec_reason(reason),
        .dec_index (dec_index)
    );

    assign dec_reason = reason;

endmodule

// File: tb/rx_daddr_filter_tb.sv
`timescale 1ns/1ps
module rx_daddr_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        dec_valid;
    logic        dec_accept;
    logic [2:0]  dec_reason;
    logic [2:0]  dec_index;

    int n_total = 0;
    int n_fail  = 0;

    localparam int R_DROP = 0, R_EXACT = 1, R_HASH = 2, R_BCAST = 3, R_PROM = 4;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    always #2.5 clk = ~clk;

    rx_daddr_filter u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
        .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_reason(dec_reason), .dec_index(dec_index)
    );

    function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
        return {b5, b4, b3, b2, b1, b0};
    endfunction

    // Bin bit j = XOR of every sixth address bit starting at j.
    function automatic int ref_bin(input logic [47:0] a);
        int r = 0;
        for (int j = 0; j < 6; j++) begin
            logic b = 1'b0;
            for (int m = j; m < 48; m += 6) b ^= a[m];
            if (b) r += (1 << j);
        end
        return r;
    endfunction

    function automatic logic [31:0] mode_word(input int p, h, b, n);
        return 32'((n << 3) | (b << 2) | (h << 1) | p);
    endfunction

    task automatic cfg_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_entry(input int i, input logic [47:0] a);
        cfg_wr(i, a[31:0]);
        cfg_wr(8 + i, {16'h0, a[47:32]});
    endtask

    task automatic send(input logic [47:0] a);
        @(negedge clk);
        da = a; da_valid = 1'b1;
        @(negedge clk);
        da_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic ea, input int er, input int ei);
        n_total++;
        if (dec_valid !== 1'b1 || dec_accept !== ea || dec_reason !== 3'(er) || dec_index !== 3'(ei)) begin
            n_fail++;
            $display("FAIL %s: got v=%0b a=%0b r=%0d i=%0d, expected v=1 a=%0b r=%0d i=%0d",
                     req, dec_valid, dec_accept, dec_reason, dec_index, ea, er, ei);
        end
    endtask

    task automatic frame(input string req, input logic [47:0] a, input logic ea,
                         input int er, input int ei);
        send(a);
        chk(req, ea, er, ei);
    endtask

    logic [47:0] S  = mk(8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    logic [47:0] U2 = mk(8'h02, 8'hA0, 8'hB0, 8'hC0, 8'hD0, 8'hE0);
    logic [47:0] U3 = mk(8'h04, 8'h10, 8'h20, 8'h30, 8'h40, 8'h50);
    logic [47:0] U5 = mk(8'h06, 8'h66, 8'h77, 8'h88, 8'h99, 8'hAA);
    logic [47:0] M1 = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
    logic [47:0] M2 = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h02);
    logic [47:0] M3 = mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h07);

    task automatic t_reset();
        n_total++;
        if (dec_valid !== 1'b0 || dec_accept !== 1'b0 || dec_reason !== 3'd0 || dec_index !== 3'd0) begin
            n_fail++;
            $display("FAIL R9: outputs after reset v=%0b a=%0b r=%0d i=%0d, expected all 0",
                     dec_valid, dec_accept, dec_reason, dec_index);
        end
        frame("R9 station addr with empty bank", S, 1'b0, R_DROP, 0);
        frame("R9 broadcast with mode zero", BCAST, 1'b1, R_BCAST, 0);
    endtask

    task automatic t_exact();
        load_entry(0, S);
        frame("R1 station addr exact", S, 1'b1, R_EXACT, 0);
        frame("R1 byte3 differs", S ^ 48'h0000_FF00_0000, 1'b0, R_DROP, 0);
        frame("R1 byte5 differs", S ^ 48'h0100_0000_0000, 1'b0, R_DROP, 0);
        cfg_wr(0, S[31:0]);
        frame("R2 low write invalidates", S, 1'b0, R_DROP, 0);
        cfg_wr(8, {16'h0, S[47:32]});
        frame("R2 high write revalidates", S, 1'b1, R_EXACT, 0);
        frame("R2 all-zero addr vs unwritten entries", 48'h0, 1'b0, R_DROP, 0);
    endtask

    task automatic t_partition();
        cfg_wr(18, mode_word(0, 0, 0, 2));
        load_entry(1, U2);
        load_entry(2, M1);
        load_entry(3, M2);
        frame("R3 unicast in unicast zone", U2, 1'b1, R_EXACT, 1);
        frame("R3 multicast in mc zone", M1, 1'b1, R_EXACT, 2);
        frame("R3 second multicast entry", M2, 1'b1, R_EXACT, 3);
        load_entry(3, U3);
        frame("R3 unicast in mc zone ignored", U3, 1'b0, R_DROP, 0);
        load_entry(1, M3);
        frame("R3 multicast in unicast zone ignored", M3, 1'b0, R_DROP, 0);
        cfg_wr(18, mode_word(0, 0, 0, 15));
        frame("R3 clamp to 8: mc entry now unicast zone", M1, 1'b0, R_DROP, 0);
        frame("R3 clamp to 8: unicast entry 3 live", U3, 1'b1, R_EXACT, 3);
    endtask

    task automatic t_priority();
        load_entry(5, U5);
        load_entry(6, U5);
        frame("R4 duplicate entries lowest wins", U5, 1'b1, R_EXACT, 5);
        cfg_wr(5, U5[31:0]);
        frame("R4 next entry after invalidation", U5, 1'b1, R_EXACT, 6);
    endtask

    task automatic t_hash();
        logic [47:0] ml, mh, ma, mb;
        int bl, bh;
        ml = '0; mh = '0; bl = 0; bh = 0;
        for (int v = 0; v < 256; v++) begin
            ma = mk(8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'(v));
            if (ref_bin(ma) < 32 && ml == '0) begin ml = ma; bl = ref_bin(ma); end
            if (ref_bin(ma) >= 32 && mh == '0) begin mh = ma; bh = ref_bin(ma); end
        end
        cfg_wr(18, mode_word(0, 1, 0, 8));
        cfg_wr(16, 32'h0);
        cfg_wr(17, 32'(1) << (bh - 32));
        frame("R5 high-word bin hit", mh, 1'b1, R_HASH, 0);
        frame("R5 low-word bin clear", ml, 1'b0, R_DROP, 0);
        cfg_wr(17, 32'h0);
        cfg_wr(16, 32'(1) << bl);
        frame("R5 low-word bin hit", ml, 1'b1, R_HASH, 0);
        frame("R5 high-word bin clear", mh, 1'b0, R_DROP, 0);
        cfg_wr(18, mode_word(0, 0, 0, 8));
        frame("R5 hash disabled", ml, 1'b0, R_DROP, 0);
        cfg_wr(18, mode_word(0, 1, 1, 8));
        cfg_wr(16, 32'hFFFF_FFFF);
        cfg_wr(17, 32'hFFFF_FFFF);
        mb = mk(8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 8'hAB);
        frame("R5 all bins accept any multicast", mb, 1'b1, R_HASH, 0);
        frame("R5 unicast never hashed", mk(8'h42, 1, 2, 3, 4, 5), 1'b0, R_DROP, 0);
        frame("R6 broadcast not hashed when disabled", BCAST, 1'b0, R_DROP, 0);
    endtask

    task automatic t_bcast();
        cfg_wr(18, mode_word(0, 0, 1, 8));
        frame("R6 broadcast disabled", BCAST, 1'b0, R_DROP, 0);
        cfg_wr(18, mode_word(0, 0, 0, 8));
        frame("R6 broadcast enabled", BCAST, 1'b1, R_BCAST, 0);
    endtask

    task automatic t_promisc();
        cfg_wr(18, mode_word(1, 0, 1, 8));
        frame("R7 promisc beats bcast disable", BCAST, 1'b1, R_PROM, 0);
        frame("R7 promisc unknown unicast", mk(8'hAA, 8'hBB, 1, 2, 3, 4), 1'b1, R_PROM, 0);
        frame("R7 promisc beats exact", S, 1'b1, R_PROM, 0);
        cfg_wr(18, mode_word(0, 0, 0, 8));
    endtask

    task automatic t_pipeline();
        @(negedge clk);
        da = S; da_valid = 1'b1;
        @(negedge clk);
        da = mk(8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D);
        @(negedge clk);
        da_valid = 1'b0;
        chk("R8 first of back-to-back", 1'b1, R_EXACT, 0);
        @(negedge clk);
        chk("R8 second of back-to-back", 1'b0, R_DROP, 0);
        @(negedge clk);
        n_total++;
        if (dec_valid !== 1'b0 || dec_accept !== 1'b0) begin
            n_fail++;
            $display("FAIL R8/R10: strobe after burst v=%0b a=%0b, expected 0 0", dec_valid, dec_accept);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_exact();
        t_partition();
        t_priority();
        t_hash();
        t_bcast();
        t_promisc();
        t_pipeline();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: run hung, got timeout, expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule